// File: doc/BRIEF.md
# Programmable Clock Edge Placement Generator

This block turns three external timing clocks into three internal sampling phases for an imaging front end. The three clocks are a black-level clamp clock, a pixel clock and a converter clock. The block runs on a fast timebase clock `clk`. One `clk` period is the fine step of 0.5 ns, so a 1 ns step is two periods.

Each external clock first passes a polarity select. Its rising and falling edges are then detected on the timebase, and each edge is delayed by its own programmed amount. The delayed edges set and clear the phase outputs. The clamp clock drives `phase1`, the pixel clock drives `phase2` and the converter clock drives `phase4`. In the chained mode, the rising edge of `phase2` is timed from the trailing edge of the clamp clock instead of from the pixel clock.

Delay fields arrive as parallel register words. They are copied into a shadow set only while the block is quiet, so that a mid-pulse write cannot cut a pulse short.

Top module: `edge_place_gen`

## Requirements

In these requirements, edge 0 is the rising `clk` edge at which an input change is first sampled. A "corrected" clock is the external clock XOR its `polSel` bit. A leading edge is a falling edge of the corrected clock, and a trailing edge is a rising edge of it. The `polSel` bits are: bit 0 for the clamp clock, bit 1 for the pixel clock, bit 2 for the converter clock. The `polSel` bits act directly and are not shadowed.

- R1: While `rst` is high, and after it, until a delayed edge arrives, `phase1` and `phase2` are 0 and `phase4` is 1.
- R2: With a `polSel` bit of 0, the leading edge of that clock is its falling edge. With a bit of 1, the leading edge is its rising edge.
- R3: A clamp-clock leading edge makes `phase1` rise at `clk` edge 2 + 2·`clampDlyReg[2:0]`.
- R4: A clamp-clock trailing edge makes `phase1` fall at edge 2 + 2·`clampDlyReg[5:3]`.
- R5: With `chainMode` 0, a pixel-clock leading edge makes `phase2` rise at edge 2 + 2·`pixDlyReg[2:0]`. In this mode `pixDlyReg[8:6]` has no effect: a clamp trailing edge leaves `phase2` unchanged.
- R6: A pixel-clock trailing edge makes `phase2` fall at edge 2 + 2·`pixDlyReg[5:3]`.
- R7: With `chainMode` 1, a clamp trailing edge makes `phase2` rise at edge 2 + 2·(`clampDlyReg[5:3]` + `pixDlyReg[8:6]`). A pixel leading edge then leaves `phase2` unchanged.
- R8: A converter-clock leading edge makes `phase4` fall at edge 2 + `convDlyReg[3:0]`.
- R9: A converter-clock trailing edge makes `phase4` rise at edge 2 + `convDlyReg[7:4]`.
- R10: A new edge of the same kind that arrives before a pending delay expires restarts that delay from the new edge. The earlier edge then produces no output change.
- R11: Delay fields and `chainMode` are copied into the shadow set only in a cycle where all three conditions hold: `phase1` is 0, `phase2` is 0, `phase4` is 1. No delayed edge may be pending in that cycle. A write at any other time takes effect once that state is reached.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one period per 0.5 ns step |
| rst | input | 1 | Synchronous active-high reset |
| clampClkIn | input | 1 | External black-level clamp clock |
| pixClkIn | input | 1 | External pixel clock |
| convClkIn | input | 1 | External converter clock |
| polSel | input | 3 | Polarity bits: [0] clamp, [1] pixel, [2] converter |
| chainMode | input | 1 | 1 = `phase2` rise chained from the clamp trailing edge |
| clampDlyReg | input | 6 | [2:0] leading delay, [5:3] trailing delay (1 ns steps) |
| pixDlyReg | input | 9 | [2:0] leading, [5:3] trailing, [8:6] chain delay (1 ns steps) |
| convDlyReg | input | 8 | [3:0] leading, [7:4] trailing delay (0.5 ns steps) |
| phase1 | output | 1 | Internal clamp phase, idle low |
| phase2 | output | 1 | Internal pixel phase, idle low |
| phase4 | output | 1 | Internal converter phase, idle high |

## Verification

Every edge is timed to the exact `clk` edge, with delay codes of zero and of full scale. A design that drops or adds a pipeline stage, or that scales the 1 ns fields wrongly, lands off by one cycle or off by a factor.

The chained mode is run in both settings. This catches a design that adds the chain field when the mode is off, that forgets the clamp trailing delay in the sum, or that still lets the pixel leading edge raise `phase2`.

A leading edge is re-issued mid-count. This exposes a counter that keeps its first load instead of restarting.

A register write lands while `phase1` is high. A design without the idle gate would use the new trailing delay at once and shorten the pulse in flight.

// File: rtl/edge_place_pkg.sv
package edge_place_pkg;

  // Register field widths (register layout fixed by the block's programming model)
  localparam int CLAMP_FLD_W = 3;
  localparam int PIX_FLD_W   = 3;
  localparam int CONV_FLD_W  = 4;
  localparam int CLAMP_REG_W = 2 * CLAMP_FLD_W;
  localparam int PIX_REG_W   = 3 * PIX_FLD_W;
  localparam int CONV_REG_W  = 2 * CONV_FLD_W;

  // External clock sources
  localparam int NUM_SRC   = 3;
  localparam int SRC_CLAMP = 0;
  localparam int SRC_PIX   = 1;
  localparam int SRC_CONV  = 2;

  // Delay timers, one per delayed edge
  localparam int NUM_TMR     = 7;
  localparam int TMR_CL_LEAD = 0;
  localparam int TMR_CL_TRL  = 1;
  localparam int TMR_PX_LEAD = 2;
  localparam int TMR_PX_TRL  = 3;
  localparam int TMR_CHAIN   = 4;
  localparam int TMR_CV_LEAD = 5;
  localparam int TMR_CV_TRL  = 6;

  typedef struct packed {
    logic [CLAMP_FLD_W-1:0] clampLead;
    logic [CLAMP_FLD_W-1:0] clampTrail;
    logic [PIX_FLD_W-1:0]   pixLead;
    logic [PIX_FLD_W-1:0]   pixTrail;
    logic [PIX_FLD_W-1:0]   pixChain;
    logic [CONV_FLD_W-1:0]  convLead;
    logic [CONV_FLD_W-1:0]  convTrail;
    logic                   chainOn;
  } dlyCfg_t;

  typedef struct packed {
    logic p1Set;
    logic p1Clr;
    logic p2Set;
    logic p2Clr;
    logic p4Set;
    logic p4Clr;
  } phaseStrobes_t;

endpackage

// File: rtl/edge_delay_timer.sv
module edge_delay_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             fire,
  output logic             armed
);

  logic [CNT_W-1:0] cntQ;

  // Expires in the cycle the count reaches zero
  assign fire = armed && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cntQ  <= '0;
    end else if (load) begin
      // a fresh edge always restarts the count
      armed <= 1'b1;
      cntQ  <= loadVal;
    end else if (fire) begin
      armed <= 1'b0;
    end else if (armed) begin
      cntQ <= cntQ - 1'b1;
    end
  end

endmodule

// File: rtl/edge_place_ctrl.sv
module edge_place_ctrl
  import edge_place_pkg::*;
#(
  parameter int COARSE_TICKS = 2,
  parameter int FINE_TICKS   = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_SRC-1:0]     extClk,
  input  logic [NUM_SRC-1:0]     polSel,
  input  logic                   chainMode,
  input  logic [CLAMP_REG_W-1:0] clampDlyReg,
  input  logic [PIX_REG_W-1:0]   pixDlyReg,
  input  logic [CONV_REG_W-1:0]  convDlyReg,
  input  logic                   phasesIdle,
  output phaseStrobes_t          strobes,
  output dlyCfg_t                cfgQ
);

  localparam int CLAMP_MAX = (1 << CLAMP_FLD_W) - 1;
  localparam int PIX_MAX   = (1 << PIX_FLD_W) - 1;
  localparam int CONV_MAX  = (1 << CONV_FLD_W) - 1;
  localparam int CHAIN_MAX = COARSE_TICKS * (CLAMP_MAX + PIX_MAX);
  localparam int CONV_TMAX = FINE_TICKS * CONV_MAX;
  localparam int MAX_LOAD  = (CHAIN_MAX > CONV_TMAX) ? CHAIN_MAX : CONV_TMAX;
  localparam int CNT_W     = $clog2(MAX_LOAD + 1);

  function automatic logic [CNT_W-1:0] toTicks(input int ticks, input int steps);
    return CNT_W'(ticks * steps);
  endfunction

  // Polarity correction, sampling and edge detection per source
  logic [NUM_SRC-1:0] sampQ, prevQ, leadDet, trailDet;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic corrected;
    assign corrected = extClk[s] ^ polSel[s];
    always_ff @(posedge clk) begin
      if (rst) begin
        sampQ[s] <= corrected;
        prevQ[s] <= corrected;
      end else begin
        sampQ[s] <= corrected;
        prevQ[s] <= sampQ[s];
      end
    end
    assign leadDet[s]  = prevQ[s] & ~sampQ[s];
    assign trailDet[s] = ~prevQ[s] & sampQ[s];
  end

  // Register field decode
  dlyCfg_t cfgNext;
  always_comb begin
    cfgNext.clampLead  = clampDlyReg[CLAMP_FLD_W-1:0];
    cfgNext.clampTrail = clampDlyReg[2*CLAMP_FLD_W-1:CLAMP_FLD_W];
    cfgNext.pixLead    = pixDlyReg[PIX_FLD_W-1:0];
    cfgNext.pixTrail   = pixDlyReg[2*PIX_FLD_W-1:PIX_FLD_W];
    cfgNext.pixChain   = pixDlyReg[3*PIX_FLD_W-1:2*PIX_FLD_W];
    cfgNext.convLead   = convDlyReg[CONV_FLD_W-1:0];
    cfgNext.convTrail  = convDlyReg[2*CONV_FLD_W-1:CONV_FLD_W];
    cfgNext.chainOn    = chainMode;
  end

  logic [NUM_TMR-1:0] armedVec, fireVec, loadEn;
  logic [CNT_W-1:0]   loadVal [NUM_TMR];

  // Shadow copy refreshed only while quiet
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '0;
    end else if (phasesIdle && !(|armedVec)) begin
      cfgQ <= cfgNext;
    end
  end

  always_comb begin
    loadEn              = '0;
    loadEn[TMR_CL_LEAD] = leadDet[SRC_CLAMP];
    loadEn[TMR_CL_TRL]  = trailDet[SRC_CLAMP];
    loadEn[TMR_PX_LEAD] = leadDet[SRC_PIX] & ~cfgQ.chainOn;
    loadEn[TMR_PX_TRL]  = trailDet[SRC_PIX];
    loadEn[TMR_CHAIN]   = trailDet[SRC_CLAMP] & cfgQ.chainOn;
    loadEn[TMR_CV_LEAD] = leadDet[SRC_CONV];
    loadEn[TMR_CV_TRL]  = trailDet[SRC_CONV];

    loadVal[TMR_CL_LEAD] = toTicks(COARSE_TICKS, int'(cfgQ.clampLead));
    loadVal[TMR_CL_TRL]  = toTicks(COARSE_TICKS, int'(cfgQ.clampTrail));
    loadVal[TMR_PX_LEAD] = toTicks(COARSE_TICKS, int'(cfgQ.pixLead));
    loadVal[TMR_PX_TRL]  = toTicks(COARSE_TICKS, int'(cfgQ.pixTrail));
    loadVal[TMR_CHAIN]   = toTicks(COARSE_TICKS,
                                   int'(cfgQ.clampTrail) + int'(cfgQ.pixChain));
    loadVal[TMR_CV_LEAD] = toTicks(FINE_TICKS, int'(cfgQ.convLead));
    loadVal[TMR_CV_TRL]  = toTicks(FINE_TICKS, int'(cfgQ.convTrail));
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    edge_delay_timer #(.CNT_W(CNT_W)) i_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (loadEn[t]),
      .loadVal (loadVal[t]),
      .fire    (fireVec[t]),
      .armed   (armedVec[t])
    );
  end

  always_comb begin
    strobes.p1Set = fireVec[TMR_CL_LEAD];
    strobes.p1Clr = fireVec[TMR_CL_TRL];
    strobes.p2Set = fireVec[TMR_PX_LEAD] | fireVec[TMR_CHAIN];
    strobes.p2Clr = fireVec[TMR_PX_TRL];
    strobes.p4Clr = fireVec[TMR_CV_LEAD];
    strobes.p4Set = fireVec[TMR_CV_TRL];
  end

endmodule

// File: rtl/edge_place_datapath.sv
module edge_place_datapath
  import edge_place_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  phaseStrobes_t strobes,
  output logic          phase1,
  output logic          phase2,
  output logic          phase4,
  output logic          phasesIdle
);

  // On a same-cycle clash the idle level wins
  always_ff @(posedge clk) begin
    if (rst) begin
      phase1 <= 1'b0;
      phase2 <= 1'b0;
      phase4 <= 1'b1;
    end else begin
      if (strobes.p1Clr)      phase1 <= 1'b0;
      else if (strobes.p1Set) phase1 <= 1'b1;
      if (strobes.p2Clr)      phase2 <= 1'b0;
      else if (strobes.p2Set) phase2 <= 1'b1;
      if (strobes.p4Set)      phase4 <= 1'b1;
      else if (strobes.p4Clr) phase4 <= 1'b0;
    end
  end

  assign phasesIdle = !phase1 && !phase2 && phase4;

endmodule

// File: rtl/edge_place_gen.sv
module edge_place_gen
  import edge_place_pkg::*;
#(
  parameter int COARSE_TICKS = 2,
  parameter int FINE_TICKS   = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clampClkIn,
  input  logic                   pixClkIn,
  input  logic                   convClkIn,
  input  logic [NUM_SRC-1:0]     polSel,
  input  logic                   chainMode,
  input  logic [CLAMP_REG_W-1:0] clampDlyReg,
  input  logic [PIX_REG_W-1:0]   pixDlyReg,
  input  logic [CONV_REG_W-1:0]  convDlyReg,
  output logic                   phase1,
  output logic                   phase2,
  output logic                   phase4
);

  phaseStrobes_t      strobes;
  dlyCfg_t            cfgShadow;
  logic               phasesIdle;
  logic [NUM_SRC-1:0] extClk;

  always_comb begin
    extClk            = '0;
    extClk[SRC_CLAMP] = clampClkIn;
    extClk[SRC_PIX]   = pixClkIn;
    extClk[SRC_CONV]  = convClkIn;
  end

  edge_place_ctrl #(
    .COARSE_TICKS (COARSE_TICKS),
    .FINE_TICKS   (FINE_TICKS)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .extClk      (extClk),
    .polSel      (polSel),
    .chainMode   (chainMode),
    .clampDlyReg (clampDlyReg),
    .pixDlyReg   (pixDlyReg),
    .convDlyReg  (convDlyReg),
    .phasesIdle  (phasesIdle),
    .strobes     (strobes),
    .cfgQ        (cfgShadow)
  );

  edge_place_datapath i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .phase1     (phase1),
    .phase2     (phase2),
    .phase4     (phase4),
    .phasesIdle (phasesIdle)
  );

endmodule

// File: rtl/edge_place_chk.sv
module edge_place_chk
  import edge_place_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          phase1,
  input logic          phase2,
  input logic          phase4,
  input phaseStrobes_t strobes,
  input dlyCfg_t       cfgShadow
);

  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: one cycle after a reset edge the phases sit at their idle levels
  always @(posedge clk) begin
    if (rstQ) begin
      p_reset_state_r1: assert (!phase1 && !phase2 && phase4);
    end
  end

  // R3: phase1 rises only from the delayed clamp leading strobe
  p_ph1_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(phase1) |-> $past(strobes.p1Set));

  // R4: phase1 falls only from the delayed clamp trailing strobe
  p_ph1_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(phase1) |-> $past(strobes.p1Clr));

  // R5, R7: phase2 rises only from the pixel-lead or chained strobe
  p_ph2_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(phase2) |-> $past(strobes.p2Set));

  // R6: phase2 falls only from the pixel trailing strobe
  p_ph2_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(phase2) |-> $past(strobes.p2Clr));

  // R8: phase4 falls only from the converter leading strobe
  p_ph4_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(phase4) |-> $past(strobes.p4Clr));

  // R9: phase4 rises only from the converter trailing strobe
  p_ph4_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(phase4) |-> $past(strobes.p4Set));

  // R11: shadow set holds while any phase is away from idle
  p_shadow_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (phase1 || phase2 || !phase4) |=> $stable(cfgShadow));

endmodule

bind edge_place_gen edge_place_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .phase1    (phase1),
  .phase2    (phase2),
  .phase4    (phase4),
  .strobes   (strobes),
  .cfgShadow (cfgShadow)
);

// File: tb/test_edge_place_gen.sv
module test_edge_place_gen;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN  = 40;
  localparam int NONE = -1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] polSel = 3'b000;
  logic       chainMode = 1'b0;
  logic [5:0] clampDlyReg = '0;
  logic [8:0] pixDlyReg = '0;
  logic [7:0] convDlyReg = '0;
  logic       cClamp = 1'b1, cPix = 1'b1, cConv = 1'b1; // corrected levels
  logic       clampClkIn, pixClkIn, convClkIn;
  logic       phase1, phase2, phase4;
  int         nChecks = 0, nFails = 0;
  bit         done = 1'b0;

  assign clampClkIn = cClamp ^ polSel[0];
  assign pixClkIn   = cPix   ^ polSel[1];
  assign convClkIn  = cConv  ^ polSel[2];

  always #4 clk = ~clk;

  edge_place_gen i_edge_place_gen (
    .clk(clk), .rst(rst),
    .clampClkIn(clampClkIn), .pixClkIn(pixClkIn), .convClkIn(convClkIn),
    .polSel(polSel), .chainMode(chainMode),
    .clampDlyReg(clampDlyReg), .pixDlyReg(pixDlyReg), .convDlyReg(convDlyReg),
    .phase1(phase1), .phase2(phase2), .phase4(phase4)
  );

  function automatic int expCoarse(int code);
    return 2 + 2 * code;
  endfunction
  function automatic int expFine(int code);
    return 2 + code;
  endfunction
  function automatic int expChain(int trl, int chn);
    return 2 + 2 * (trl + chn);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Call right after driving at a negedge; k=0 is the next rising edge
  task automatic observe(output int t1, output int t2, output int t4);
    logic b1, b2, b4;
    b1 = phase1; b2 = phase2; b4 = phase4;
    t1 = NONE; t2 = NONE; t4 = NONE;
    for (int k = 0; k < WIN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (t1 == NONE && phase1 != b1) t1 = k;
      if (t2 == NONE && phase2 != b2) t2 = k;
      if (t4 == NONE && phase4 != b4) t4 = k;
    end
  endtask

  task automatic runPulseSet(input logic [2:0] pol, input logic opt,
                             input logic [5:0] cd, input logic [8:0] pd,
                             input logic [7:0] vd);
    int t1, t2, t4;
    int a, b, pa, pb, pc, ca, cb;
    @(negedge clk);
    polSel = pol; chainMode = opt;
    clampDlyReg = cd; pixDlyReg = pd; convDlyReg = vd;
    repeat (4) @(negedge clk);
    a = int'(cd[2:0]); b = int'(cd[5:3]);
    pa = int'(pd[2:0]); pb = int'(pd[5:3]); pc = int'(pd[8:6]);
    ca = int'(vd[3:0]); cb = int'(vd[7:4]);
    // all leading edges together
    cClamp = 1'b0; cPix = 1'b0; cConv = 1'b0;
    observe(t1, t2, t4);
    check("R2,R3 phase1 rise", t1, expCoarse(a));
    check("R2,R8 phase4 fall", t4, expFine(ca));
    if (opt) check("R7 pixel lead ignored", t2, NONE);
    else     check("R2,R5 phase2 rise", t2, expCoarse(pa));
    // pixel trailing alone
    @(negedge clk); cPix = 1'b1;
    observe(t1, t2, t4);
    if (opt) check("R7 phase2 stays low", t2, NONE);
    else     check("R6 phase2 fall", t2, expCoarse(pb));
    // clamp trailing alone
    @(negedge clk); cClamp = 1'b1;
    observe(t1, t2, t4);
    check("R4 phase1 fall", t1, expCoarse(b));
    if (opt) check("R7 chained phase2 rise", t2, expChain(b, pc));
    else     check("R5 chain field ignored", t2, NONE);
    // pixel leading again
    @(negedge clk); cPix = 1'b0;
    observe(t1, t2, t4);
    if (opt) check("R7 pixel lead ignored", t2, NONE);
    else     check("R5 phase2 rise", t2, expCoarse(pa));
    // pixel trailing
    @(negedge clk); cPix = 1'b1;
    observe(t1, t2, t4);
    check("R6 phase2 fall", t2, expCoarse(pb));
    // converter trailing
    @(negedge clk); cConv = 1'b1;
    observe(t1, t2, t4);
    check("R9 phase4 rise", t4, expFine(cb));
  endtask

  initial begin
    int t1, t2, t4;
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 phase1 in reset", int'(phase1), 0);
    check("R1 phase4 in reset", int'(phase4), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 phase1 after reset", int'(phase1), 0);
    check("R1 phase2 after reset", int'(phase2), 0);
    check("R1 phase4 after reset", int'(phase4), 1);

    // directed extremes
    runPulseSet(3'b000, 1'b0, '0, '0, '0);
    runPulseSet(3'b111, 1'b1, '1, '1, '1);
    runPulseSet(3'b101, 1'b1, 6'b111_000, 9'b111_000_000, 8'hf0);
    runPulseSet(3'b010, 1'b0, 6'b000_111, 9'b111_111_000, 8'h0f);

    // R10: restart of a pending leading delay
    @(negedge clk);
    polSel = 3'b000; chainMode = 1'b0;
    clampDlyReg = 6'b000_111; pixDlyReg = '0; convDlyReg = '0;
    repeat (4) @(negedge clk);
    cClamp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); cClamp = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); cClamp = 1'b0;
    observe(t1, t2, t4);
    check("R10 restarted lead delay", t1, 16);
    @(negedge clk); cClamp = 1'b1;
    observe(t1, t2, t4);
    check("R10 R4 fall after restart", t1, 2);

    // R11: write while phase1 high is deferred
    @(negedge clk);
    clampDlyReg = 6'b001_000;
    repeat (4) @(negedge clk);
    cClamp = 1'b0;
    observe(t1, t2, t4);
    check("R11 R3 lead", t1, 2);
    @(negedge clk); clampDlyReg = 6'b101_000;
    repeat (5) @(negedge clk);
    cClamp = 1'b1;
    observe(t1, t2, t4);
    check("R11 old trail delay kept", t1, 4);
    repeat (4) @(negedge clk);
    cClamp = 1'b0;
    observe(t1, t2, t4);
    @(negedge clk); cClamp = 1'b1;
    observe(t1, t2, t4);
    check("R11 new trail delay after idle", t1, 12);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      runPulseSet(3'($urandom), 1'($urandom), 6'($urandom), 9'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule